// File: doc/BRIEF.md
# HDLC Bit-Stuffing Frame Transmitter

This block turns frames held in a byte-wide transmit queue into a single-bit HDLC line stream. Each frame is wrapped in an opening flag and a closing flag. A zero is inserted after every run of five ones in the payload and in the check sequence. A 16-bit frame check sequence (FCS) is appended after the byte tagged as last. When no frame is in progress, the line carries a fill pattern. A mode input chooses the fill: repeated flags or all-ones idle bytes.

A new bit is produced once every `BIT_DIV` clocks. It appears on `line_bit` together with a one-cycle `line_vld` strobe. The queue is read through a valid/pop handshake. Each entry carries a data byte, an end-of-frame tag and an abort tag. `q_pop` is high for one cycle at the moment the transmitter takes the head entry.

The controller has seven states. FILL sends fill units. OPEN sends the opening flag. DATA sends a payload byte. FCS sends the check sequence. CLOSE sends the closing flag. ABORT sends the abort pattern. FAULT is a trap state. The transitions are as follows:
- FILL, CLOSE and ABORT each go to OPEN at the end of their unit when the queue has data and the enable is high. Otherwise they go to FILL.
- OPEN takes a byte and goes to DATA, ABORT or FAULT.
- DATA goes to FCS after the last byte. Otherwise it takes the next byte.
- FCS goes to CLOSE.
- FAULT is left only through reset.

Top module: `hdlc_frame_tx`

## Requirements
- R1: Reset, which is active low on `rst_n`, puts the block into FILL with `line_vld`, `q_pop` and `tx_fault` low. Outside FAULT, `line_vld` pulses once every `BIT_DIV` clocks, and each pulse carries one new bit on `line_bit`.
- R2: Fill units are 8 bits long. With `fill_flags`=1 a unit is the flag 0,1,1,1,1,1,1,0 in line order. With `fill_flags`=0 a unit is eight ones. The mode is sampled at the first bit of each fill unit.
- R3: A frame begins with an opening flag only at a unit boundary where `q_valid` and `tx_en` are both 1. With `tx_en`=0 the line stays in fill and no entry is popped.
- R4: Payload bytes go out least-significant bit first. Exactly one entry is popped per byte, at the end of the preceding unit.
- R5: After five consecutive ones of payload or FCS, a 0 is inserted before the next bit, whatever that next bit is. Ones in flags, fill and abort patterns are never counted.
- R6: The FCS uses polynomial 0x1021. It is preset to 0xFFFF and shifts in the payload bits in line order. Its complement follows the byte tagged end-of-frame, bit 15 first, and is followed by a closing flag.
- R7: Back-to-back frames are separated by a complete closing flag and a complete opening flag: 16 bits with no shared zero.
- R8: An entry tagged abort is sent as 0 followed by seven ones, with no FCS and no closing flag. This holds even when it is the first entry of the frame. The next unit is fill or a new opening flag.
- R9: An entry tagged both abort and end-of-frame drives `tx_fault` high. The block then stops `line_vld` and `q_pop` until reset, and after reset it sends frames normally.
- R10: If the queue is empty when the next byte of an open frame is due, the abort pattern is sent in that byte's place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous transmitter reset |
| tx_en | input | 1 | Allows a new frame to start |
| fill_flags | input | 1 | Fill mode: 1 flags, 0 all-ones |
| q_valid | input | 1 | Queue head entry present |
| q_data | input | 8 | Queue head data byte |
| q_eof | input | 1 | Head entry is the last byte of its frame |
| q_abort | input | 1 | Head entry is replaced by the abort pattern |
| q_pop | output | 1 | Head entry taken this cycle |
| line_bit | output | 1 | Serial line bit |
| line_vld | output | 1 | Strobe marking a new line bit |
| tx_fault | output | 1 | Trap state entered |

## Verification
The bench covers the following corner cases, and each one catches a specific kind of defect:
- Bytes of 0xFF, 0xF8 and 0x1F are sent so that runs of ones cross byte boundaries and run into the FCS and the closing flag. A design that resets its ones count per byte, or forgets to stuff before the closing flag, misplaces every later bit.
- Two frames are queued together. A design that merges the flags, or adds fill between them, shows up as a 15-bit or oversized gap.
- An abort is tagged on the first byte and also after a stuffed byte. An underrun is produced by leaving the queue empty mid-frame. A wrong design would emit an FCS, a closing flag or stale data instead of the abort pattern.
- The enable is held low while the queue is loaded, and the fill mode is switched between frames. A design that starts early would pop an entry the bench still expects to see.
- The dual-tag entry is sent, and the bench confirms that the line falls silent and stays silent until reset.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_FILL,
        ST_OPEN,
        ST_DATA,
        ST_FCS,
        ST_CLOSE,
        ST_ABORT,
        ST_FAULT
    } tx_state_e;

    // patterns are indexed by line order: bit 0 leaves first
    localparam logic [BYTE_W-1:0] FLAG_PAT  = 8'b0111_1110;
    localparam logic [BYTE_W-1:0] ABORT_PAT = 8'b1111_1110;
endpackage

// File: rtl/hdlc_tx_tick.sv
module hdlc_tx_tick #(
    parameter int BIT_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    generate
        if (BIT_DIV > 1) begin : g_div
            localparam int CW = $clog2(BIT_DIV);
            localparam logic [CW-1:0] LAST = CW'(BIT_DIV - 1);
            logic [CW-1:0] cnt_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)            cnt_q <= '0;
                else if (cnt_q == LAST) cnt_q <= '0;
                else                   cnt_q <= cnt_q + 1'b1;
            end
            assign tick = (cnt_q == LAST);
        end else begin : g_full
            assign tick = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/hdlc_tx_fcs.sv
module hdlc_tx_fcs #(
    parameter int          FCS_W = 16,
    parameter logic [15:0] POLY  = 16'h1021,
    parameter logic [15:0] SEED  = 16'hFFFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic             upd,
    input  logic             din,
    output logic [FCS_W-1:0] fcs
);
    logic [FCS_W-1:0] fcs_q;
    logic             fb;

    assign fb = fcs_q[FCS_W-1] ^ din;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    fcs_q <= SEED[FCS_W-1:0];
        else if (init) fcs_q <= SEED[FCS_W-1:0];
        else if (upd)  fcs_q <= {fcs_q[FCS_W-2:0], 1'b0} ^ (fb ? POLY[FCS_W-1:0] : '0);
    end
    assign fcs = fcs_q;

    // R6: the register only moves on a preset or a payload bit
    p_fcs_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!init && !upd) |=> $stable(fcs_q));
endmodule

// File: rtl/hdlc_tx_stuff.sv
module hdlc_tx_stuff #(
    parameter int RUN = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic count_ok,
    input  logic bit_in,
    output logic need_zero
);
    localparam int CW = $clog2(RUN + 1);
    localparam logic [CW-1:0] RUN_V = CW'(RUN);
    logic [CW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= '0;
        else if (step) run_q <= (count_ok && bit_in) ? run_q + 1'b1 : '0;
    end
    assign need_zero = (run_q == RUN_V);

    // R5: the run never grows past the stuffing threshold
    p_run_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RUN_V);
endmodule

// File: rtl/hdlc_frame_tx.sv
module hdlc_frame_tx
    import hdlc_tx_pkg::*;
#(
    parameter int          BIT_DIV  = 4,
    parameter int          FCS_W    = 16,
    parameter logic [15:0] FCS_POLY = 16'h1021,
    parameter logic [15:0] FCS_SEED = 16'hFFFF,
    parameter int          ONES_RUN = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              fill_flags,
    input  logic              q_valid,
    input  logic [BYTE_W-1:0] q_data,
    input  logic              q_eof,
    input  logic              q_abort,
    output logic              q_pop,
    output logic              line_bit,
    output logic              line_vld,
    output logic              tx_fault
);
    localparam int IDX_W = $clog2(FCS_W);
    localparam logic [IDX_W-1:0] FCS_LAST  = IDX_W'(FCS_W - 1);
    localparam logic [IDX_W-1:0] BYTE_LAST = IDX_W'(BYTE_W - 1);

    tx_state_e         state_q, state_d;
    logic [IDX_W-1:0]  idx_q, idx_d;
    logic [BYTE_W-1:0] byte_q, byte_d;
    logic              last_q, last_d;
    logic              fill_q, fill_d;
    logic              tick, need_zero, insert, stuffable, unit_end;
    logic              unit_bit, tx_bit, fill_sel, pop_req;
    logic [FCS_W-1:0]  fcs;
    logic              bit_q, vld_q;

    hdlc_tx_tick #(.BIT_DIV(BIT_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    hdlc_tx_fcs #(.FCS_W(FCS_W), .POLY(FCS_POLY), .SEED(FCS_SEED)) u_fcs (
        .clk(clk), .rst_n(rst_n),
        .init(tick && state_q == ST_OPEN),
        .upd(tick && !insert && state_q == ST_DATA),
        .din(tx_bit), .fcs(fcs)
    );

    hdlc_tx_stuff #(.RUN(ONES_RUN)) u_stuff (
        .clk(clk), .rst_n(rst_n),
        .step(tick && state_q != ST_FAULT),
        .count_ok(stuffable && !insert),
        .bit_in(tx_bit), .need_zero(need_zero)
    );

    assign stuffable = (state_q == ST_DATA) || (state_q == ST_FCS);
    assign insert    = need_zero && (state_q != ST_FAULT);
    assign unit_end  = (state_q == ST_FCS) ? (idx_q == FCS_LAST) : (idx_q == BYTE_LAST);

    // bit selection for the current unit
    always_comb begin
        fill_sel = (idx_q == '0) ? fill_flags : fill_q;
        unique case (state_q)
            ST_FILL:           unit_bit = fill_sel ? FLAG_PAT[idx_q[2:0]] : 1'b1;
            ST_OPEN, ST_CLOSE: unit_bit = FLAG_PAT[idx_q[2:0]];
            ST_ABORT:          unit_bit = ABORT_PAT[idx_q[2:0]];
            ST_DATA:           unit_bit = byte_q[idx_q[2:0]];
            ST_FCS:            unit_bit = ~fcs[FCS_LAST - idx_q];
            default:           unit_bit = 1'b1;
        endcase
        tx_bit = insert ? 1'b0 : unit_bit;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        byte_d  = byte_q;
        last_d  = last_q;
        fill_d  = fill_q;
        pop_req = 1'b0;
        if (tick && !insert && state_q != ST_FAULT) begin
            idx_d = unit_end ? '0 : idx_q + 1'b1;
            if (state_q == ST_FILL && idx_q == '0) fill_d = fill_flags;
            if (unit_end) begin
                unique case (state_q)
                    ST_FILL, ST_CLOSE, ST_ABORT:
                        state_d = (tx_en && q_valid) ? ST_OPEN : ST_FILL;
                    ST_OPEN:
                        pop_req = 1'b1;
                    ST_DATA:
                        if (last_q) state_d = ST_FCS;
                        else        pop_req = 1'b1;
                    ST_FCS:
                        state_d = ST_CLOSE;
                    default:
                        state_d = state_q;
                endcase
                if (pop_req) begin
                    if (!q_valid)               state_d = ST_ABORT;
                    else if (q_abort && q_eof)  state_d = ST_FAULT;
                    else if (q_abort)           state_d = ST_ABORT;
                    else begin
                        state_d = ST_DATA;
                        byte_d  = q_data;
                        last_d  = q_eof;
                    end
                end
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FILL;
            idx_q   <= '0;
            byte_q  <= '0;
            last_q  <= 1'b0;
            fill_q  <= 1'b1;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            byte_q  <= byte_d;
            last_q  <= last_d;
            fill_q  <= fill_d;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q <= 1'b1;
            vld_q <= 1'b0;
        end else begin
            vld_q <= tick && (state_q != ST_FAULT);
            if (tick) bit_q <= (state_q == ST_FAULT) ? 1'b1 : tx_bit;
        end
    end

    assign q_pop    = tick && pop_req && q_valid;
    assign line_bit = bit_q;
    assign line_vld = vld_q;
    assign tx_fault = (state_q == ST_FAULT);

    // R5: a pending insertion always produces a zero on the line
    p_stuff_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && insert) |=> (line_vld && !line_bit));

    // R9: the trap is sticky and silent
    p_fault_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_fault |=> (tx_fault && !line_vld));

    p_no_pop_fault_r9: assert property (@(posedge clk) disable iff (!rst_n)
        q_pop |-> !tx_fault);

    // R3: an opening flag is entered only with data and enable present
    p_open_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OPEN && $past(state_q) != ST_OPEN) |-> $past(tx_en && q_valid));

    generate
        if (BIT_DIV > 1) begin : g_strobe_chk
            // R1: strobes are isolated single-cycle pulses
            p_strobe_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
                line_vld |=> !line_vld);
        end
    endgenerate
endmodule

// File: tb/tb_hdlc_frame_tx.sv
module tb_hdlc_frame_tx;
    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0;
    logic       fill_flags = 1'b1;
    logic       q_valid = 1'b0;
    logic [7:0] q_data = '0;
    logic       q_eof = 1'b0;
    logic       q_abort = 1'b0;
    logic       q_pop, line_bit, line_vld, tx_fault;

    always #2.5 clk = ~clk;

    hdlc_frame_tx #(.BIT_DIV(DIV)) dut (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .fill_flags(fill_flags),
        .q_valid(q_valid), .q_data(q_data), .q_eof(q_eof), .q_abort(q_abort),
        .q_pop(q_pop), .line_bit(line_bit), .line_vld(line_vld), .tx_fault(tx_fault)
    );

    typedef struct packed { logic [7:0] d; logic eof; logic ab; } qent_t;
    qent_t tq[$];
    logic  exp_b[$];
    string exp_t[$];
    int    checks = 0, fails = 0;
    int    bones = 0;
    logic [15:0] crc;
    logic  mon_en = 1'b1;
    logic  pend = 1'b0;
    int    cyc = 0, last_vld = -1;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, expv, cyc);
        end
    endtask

    // queue model: entry leaves the cycle after the design took it
    always @(negedge clk) begin
        cyc++;
        if (pend && tq.size() != 0) void'(tq.pop_front());
        pend = q_pop;
        q_valid = (tq.size() != 0);
        if (tq.size() != 0) begin
            q_data = tq[0].d; q_eof = tq[0].eof; q_abort = tq[0].ab;
        end else begin
            q_data = '0; q_eof = 1'b0; q_abort = 1'b0;
        end
    end

    // monitor: compare each strobed bit against the scoreboard
    always @(negedge clk) begin
        if (!rst_n) last_vld = -1;
        else if (mon_en && line_vld) begin
            if (exp_b.size() == 0) begin
                check(1'b0, "R1 unexpected bit", 1, 0);
            end else begin
                logic  e;
                string t;
                e = exp_b.pop_front();
                t = exp_t.pop_front();
                check(line_bit === e, t, line_bit, e);
            end
            if (last_vld >= 0) check(cyc - last_vld == DIV, "R1 strobe spacing", cyc - last_vld, DIV);
            last_vld = cyc;
        end
    end

    task automatic put(input logic b, input bit st, input string tag);
        if (bones == 5) begin
            exp_b.push_back(1'b0); exp_t.push_back("R5");
            bones = 0;
        end
        exp_b.push_back(b); exp_t.push_back(tag);
        bones = (st && b) ? bones + 1 : 0;
    endtask

    task automatic put_unit(input logic [7:0] p, input string tag);
        for (int i = 0; i < 8; i++) put(p[i], 1'b0, tag);
    endtask

    task automatic exp_fill(input bit m);
        put_unit(m ? 8'h7E : 8'hFF, "R2");
    endtask

    task automatic exp_open(input string tag);
        crc = 16'hFFFF;
        put_unit(8'h7E, tag);
    endtask

    task automatic exp_data(input logic [7:0] d);
        for (int i = 0; i < 8; i++) begin
            logic fb;
            put(d[i], 1'b1, "R4");
            fb = crc[15] ^ d[i];
            crc = {crc[14:0], 1'b0};
            if (fb) crc = crc ^ 16'h1021;
        end
    endtask

    task automatic exp_close();
        for (int i = 0; i < 16; i++) put(~crc[15-i], 1'b1, "R6");
        put_unit(8'h7E, "R6");
    endtask

    task automatic exp_abort(input string tag);
        put_unit(8'hFE, tag);
    endtask

    task automatic drain();
        while (exp_b.size() != 0) @(negedge clk);
    endtask

    task automatic qadd(input logic [7:0] d, input logic e, input logic a);
        tq.push_back('{d: d, eof: e, ab: a});
    endtask

    initial begin
        bit seen;
        repeat (3) @(negedge clk);
        check(line_vld == 0 && q_pop == 0 && tx_fault == 0, "R1 reset outputs", line_vld, 0);
        exp_fill(1); exp_fill(1);
        rst_n = 1'b1;

        // switch to all-ones fill
        drain(); fill_flags = 1'b0;
        exp_fill(0); exp_fill(0);

        // R3: queued data held back while disabled
        drain(); qadd(8'h3C, 1, 0);
        exp_fill(0); exp_fill(0);
        drain();
        check(q_valid == 1, "R3 no pop while disabled", q_valid, 1);
        tx_en = 1'b1;
        exp_fill(0); exp_open("R3"); exp_data(8'h3C); exp_close();
        drain(); check(tq.size() == 0, "R4 single pop", tq.size(), 0);

        // R5: runs of ones across bytes and into the FCS
        fill_flags = 1'b1;
        qadd(8'hFF, 0, 0); qadd(8'hF8, 0, 0); qadd(8'h1F, 1, 0);
        exp_fill(1); exp_open("R3"); exp_data(8'hFF); exp_data(8'hF8); exp_data(8'h1F); exp_close();
        drain(); check(tq.size() == 0, "R4 pops per byte", tq.size(), 0);

        // R7: back-to-back frames
        qadd(8'h12, 0, 0); qadd(8'h34, 1, 0); qadd(8'hA5, 1, 0);
        exp_fill(1); exp_open("R3"); exp_data(8'h12); exp_data(8'h34); exp_close();
        exp_open("R7"); exp_data(8'hA5); exp_close();
        drain();

        // R8: abort on first byte
        qadd(8'h00, 0, 1);
        exp_fill(1); exp_open("R3"); exp_abort("R8");
        drain();

        // R8: abort after a stuffed byte
        qadd(8'h7F, 0, 0); qadd(8'h55, 0, 1);
        exp_fill(1); exp_open("R3"); exp_data(8'h7F); exp_abort("R8");
        drain();

        // R10: underrun mid-frame
        qadd(8'hC3, 0, 0);
        exp_fill(1); exp_open("R3"); exp_data(8'hC3); exp_abort("R10");
        drain();

        // R9: both tags set
        fill_flags = 1'b0;
        qadd(8'h55, 1, 1);
        exp_fill(0); exp_open("R9");
        drain();
        mon_en = 1'b0;
        seen = 0;
        repeat (40) begin
            @(negedge clk);
            if (line_vld || q_pop) seen = 1;
        end
        check(tx_fault == 1, "R9 fault flag", tx_fault, 1);
        check(seen == 0, "R9 line silent", seen, 0);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(tx_fault == 0, "R9 cleared by reset", tx_fault, 0);
        bones = 0;
        tq.delete();
        qadd(8'h81, 1, 0);
        exp_fill(0); exp_fill(0); exp_open("R9"); exp_data(8'h81); exp_close();
        mon_en = 1'b1;
        tx_en = 1'b0;
        rst_n = 1'b1;
        repeat (DIV * 10) @(negedge clk);
        tx_en = 1'b1;
        drain();
        mon_en = 1'b0;

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule